// File: doc/BRIEF.md
# Privileged Return and Trap-Check Controller

This block carries out the privileged control instructions of a processor core: the supervisor-level return, the machine-level return, wait-for-interrupt, and the address-translation fence. The core presents one instruction at a time on a one-hot request bus. It also supplies the current privilege level, the status word, both saved exception PCs, and a flag that says whether compressed instructions are supported. The block decides whether the instruction may run at all. For a permitted return it pops the interrupt-enable and previous-privilege stack in the status word, switches privilege and redirects the PC.

All results are registered and appear one clock after the request. The privilege, status and PC outputs are architectural state. They change only when a return completes. They stay as they are for exceptions, for wait-for-interrupt, for the fence, for idle cycles and for malformed requests. Wait-for-interrupt and the fence produce single-cycle pulses, a halt request and a TLB flush, which the surrounding core acts on. Trap entry, interrupt wake-up and the TLB itself are outside this block.

Top module: `priv_ret_ctrl`

## Requirements
- R1: Privilege encoding is user 2'b00, supervisor 2'b01, machine 2'b11. A supervisor return (request bit 0) raises an illegal-instruction exception when the current privilege is user. A machine return (request bit 1) raises it for any privilege other than machine.
- R2: When the privilege check passes, `compressed_i` is 0 and the low two bits of the return target (`sepc_i` for a supervisor return, `mepc_i` for a machine return) are non-zero, a misaligned-address exception is raised. With `compressed_i` at 1, such a target is accepted unchanged.
- R3: A supervisor return is illegal when status bit 22 (trap-return) is set. This check ranks below both the privilege check and the alignment check, so a misaligned target with bit 22 set reports only the misaligned exception.
- R4: A completed supervisor return sets `pc_o` to `sepc_i` and `priv_o` to {0, status bit 8}. In the status word, bit 1 takes the old bit 5, bit 5 becomes 0 and bit 8 becomes 0, and every other bit is copied from `status_i`.
- R5: A completed machine return sets `pc_o` to `mepc_i` and `priv_o` to status bits [12:11]. The reserved value 2'b10 in those bits gives user. In the status word, bit 3 takes the old bit 7, bit 7 becomes 0 and bits [12:11] become 2'b00, and every other bit is copied.
- R6: Wait-for-interrupt (request bit 2) is illegal in supervisor mode when status bit 21 is set. Otherwise it gives a one-cycle `halt_o` pulse. User and machine mode are never trapped.
- R7: The translation fence (request bit 3) is illegal in supervisor mode when status bit 20 is set. Otherwise it gives a one-cycle `tlb_flush_o` pulse.
- R8: The two exception outputs are never high together. While either is high, `priv_o`, `status_o` and `pc_o` hold their previous values. Wait-for-interrupt and the fence never change these outputs either.
- R9: A request with no bit set, or with more than one bit set, has no effect. All pulse outputs stay low and the state outputs hold.
- R10: All results appear exactly one clock after the request. During reset `priv_o` is machine, `status_o` and `pc_o` are 0, and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | One-hot request: bit0 supervisor return, bit1 machine return, bit2 wait-for-interrupt, bit3 fence |
| priv_i | input | 2 | Current privilege level |
| status_i | input | XLEN | Current status word |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| compressed_i | input | 1 | Compressed instructions supported |
| exc_illegal_o | output | 1 | Illegal-instruction exception pulse |
| exc_misaligned_o | output | 1 | Misaligned instruction-address exception pulse |
| pc_o | output | XLEN | Next PC after a completed return |
| priv_o | output | 2 | Privilege level after a completed return |
| status_o | output | XLEN | Status word after a completed return |
| halt_o | output | 1 | Halt request pulse |
| tlb_flush_o | output | 1 | TLB flush pulse |

## Verification
The bench first targets the order of the return checks. A misaligned supervisor target with the trap-return bit also set must report only the misaligned exception. A design that checked the trap bit first would report illegal instead. The bench then covers the reserved machine previous-privilege value, which must land in user mode; a design that copied the field through would enter the reserved level. It checks that a trapped or malformed instruction leaves the privilege, status and PC untouched, which catches a design that commits state before its checks resolve. It also checks that the halt and flush pulses last exactly one cycle and are issued only when the trap bit and supervisor mode do not coincide.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam int REQ_W     = 4;
  localparam int REQ_SRET  = 0;
  localparam int REQ_MRET  = 1;
  localparam int REQ_WFI   = 2;
  localparam int REQ_FENCE = 3;

  localparam int NUM_RET = 2;
  localparam int NUM_SYS = 2;

  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;
  localparam int ST_TVM  = 20;
  localparam int ST_TW   = 21;
  localparam int ST_TSR  = 22;

  typedef struct packed {
    logic illegal;
    logic misaligned;
  } exc_t;
endpackage

// File: rtl/prc_req_decode.sv
module prc_req_decode
  import prc_pkg::*;
#(
  parameter int W = REQ_W
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] valid_o
);
  logic [$clog2(W+1)-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + {{($clog2(W+1)-1){1'b0}}, req_i[i]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign valid_o[g] = req_i[g] && (ones == 1);
    end
  endgenerate
endmodule

// File: rtl/prc_ret_check.sv
module prc_ret_check
  import prc_pkg::*;
#(
  parameter logic [1:0] MIN_PRIV = 2'b01,
  parameter bit         HAS_TRAP = 1'b1
) (
  input  logic       active_i,
  input  logic [1:0] priv_i,
  input  logic [1:0] target_lo_i,
  input  logic       compressed_i,
  input  logic       trap_bit_i,
  output exc_t       exc_o
);
  logic priv_bad;
  logic align_bad;
  logic trap_bad;

  always_comb begin
    priv_bad  = (priv_i < MIN_PRIV);
    align_bad = !compressed_i && (target_lo_i != 2'b00);
    trap_bad  = HAS_TRAP && trap_bit_i;
    exc_o     = '0;
    if (active_i) begin
      if (priv_bad) begin
        exc_o.illegal = 1'b1;
      end else if (align_bad) begin
        exc_o.misaligned = 1'b1;
      end else if (trap_bad) begin
        exc_o.illegal = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prc_status_pop.sv
module prc_status_pop
  import prc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IE_BIT  = 1,
  parameter int PIE_BIT = 5,
  parameter int PP_LSB  = 8,
  parameter int PP_W    = 1
) (
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] status_o,
  output logic [1:0]      priv_o
);
  logic [PP_W-1:0] pp;

  assign pp = status_i[PP_LSB +: PP_W];

  always_comb begin
    status_o                  = status_i;
    status_o[IE_BIT]          = status_i[PIE_BIT];
    status_o[PIE_BIT]         = 1'b0;
    status_o[PP_LSB +: PP_W]  = '0;
  end

  generate
    if (PP_W == 1) begin : g_narrow
      assign priv_o = {1'b0, pp[0]};
    end else begin : g_wide
      logic [1:0] pp2;
      assign pp2    = pp[1:0];
      assign priv_o = (pp2 == PRIV_RSV) ? PRIV_U : pp2;
    end
  endgenerate
endmodule

// File: rtl/prc_sys_check.sv
module prc_sys_check
  import prc_pkg::*;
(
  input  logic       active_i,
  input  logic [1:0] priv_i,
  input  logic       trap_bit_i,
  output logic       illegal_o,
  output logic       grant_o
);
  logic trapped;

  assign trapped   = (priv_i == PRIV_S) && trap_bit_i;
  assign illegal_o = active_i && trapped;
  assign grant_o   = active_i && !trapped;
endmodule

// File: rtl/priv_ret_ctrl.sv
module priv_ret_ctrl
  import prc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      req_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] sepc_i,
  input  logic [XLEN-1:0] mepc_i,
  input  logic            compressed_i,
  output logic            exc_illegal_o,
  output logic            exc_misaligned_o,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] status_o,
  output logic            halt_o,
  output logic            tlb_flush_o
);
  logic [REQ_W-1:0] valid;

  prc_req_decode #(.W(REQ_W)) u_dec (
    .req_i   (req_i),
    .valid_o (valid)
  );

  // Return paths: index 0 supervisor, index 1 machine
  exc_t            ret_exc    [NUM_RET];
  logic [XLEN-1:0] ret_status [NUM_RET];
  logic [1:0]      ret_priv   [NUM_RET];
  logic [XLEN-1:0] ret_pc     [NUM_RET];
  logic            ret_go     [NUM_RET];

  assign ret_pc[0] = sepc_i;
  assign ret_pc[1] = mepc_i;

  genvar g;
  generate
    for (g = 0; g < NUM_RET; g++) begin : g_ret
      localparam bit         IS_M     = (g == 1);
      localparam logic [1:0] MIN_P    = IS_M ? PRIV_M : PRIV_S;
      localparam int         IE_B     = IS_M ? ST_MIE : ST_SIE;
      localparam int         PIE_B    = IS_M ? ST_MPIE : ST_SPIE;
      localparam int         PP_B     = IS_M ? ST_MPP : ST_SPP;
      localparam int         PP_WID   = IS_M ? 2 : 1;

      prc_ret_check #(.MIN_PRIV(MIN_P), .HAS_TRAP(!IS_M)) u_chk (
        .active_i     (valid[g]),
        .priv_i       (priv_i),
        .target_lo_i  (ret_pc[g][1:0]),
        .compressed_i (compressed_i),
        .trap_bit_i   (status_i[ST_TSR]),
        .exc_o        (ret_exc[g])
      );

      prc_status_pop #(
        .XLEN(XLEN), .IE_BIT(IE_B), .PIE_BIT(PIE_B),
        .PP_LSB(PP_B), .PP_W(PP_WID)
      ) u_pop (
        .status_i (status_i),
        .status_o (ret_status[g]),
        .priv_o   (ret_priv[g])
      );

      assign ret_go[g] = valid[g] && !ret_exc[g].illegal && !ret_exc[g].misaligned;
    end
  endgenerate

  // System paths: index 0 wait-for-interrupt, index 1 fence
  logic sys_ill   [NUM_SYS];
  logic sys_grant [NUM_SYS];
  logic sys_trap  [NUM_SYS];

  assign sys_trap[0] = status_i[ST_TW];
  assign sys_trap[1] = status_i[ST_TVM];

  generate
    for (g = 0; g < NUM_SYS; g++) begin : g_sys
      prc_sys_check u_sys (
        .active_i   (valid[REQ_WFI + g]),
        .priv_i     (priv_i),
        .trap_bit_i (sys_trap[g]),
        .illegal_o  (sys_ill[g]),
        .grant_o    (sys_grant[g])
      );
    end
  endgenerate

  // Next-state logic
  logic            ill_d, mis_d, halt_d, flush_d;
  logic            commit;
  logic [XLEN-1:0] pc_d, status_d;
  logic [1:0]      priv_d;

  always_comb begin
    ill_d    = 1'b0;
    mis_d    = 1'b0;
    halt_d   = sys_grant[0];
    flush_d  = sys_grant[1];
    commit   = 1'b0;
    pc_d     = pc_o;
    status_d = status_o;
    priv_d   = priv_o;
    for (int i = 0; i < NUM_RET; i++) begin
      ill_d = ill_d | ret_exc[i].illegal;
      mis_d = mis_d | ret_exc[i].misaligned;
      if (ret_go[i]) begin
        commit   = 1'b1;
        pc_d     = ret_pc[i];
        status_d = ret_status[i];
        priv_d   = ret_priv[i];
      end
    end
    for (int i = 0; i < NUM_SYS; i++) begin
      ill_d = ill_d | sys_ill[i];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_illegal_o    <= 1'b0;
      exc_misaligned_o <= 1'b0;
      halt_o           <= 1'b0;
      tlb_flush_o      <= 1'b0;
    end else begin
      exc_illegal_o    <= ill_d;
      exc_misaligned_o <= mis_d;
      halt_o           <= halt_d;
      tlb_flush_o      <= flush_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o     <= '0;
      status_o <= '0;
      priv_o   <= PRIV_M;
    end else if (commit) begin
      pc_o     <= pc_d;
      status_o <= status_d;
      priv_o   <= priv_d;
    end
  end
endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      req_i,
  input logic [1:0]      priv_i,
  input logic [XLEN-1:0] status_i,
  input logic [XLEN-1:0] sepc_i,
  input logic [XLEN-1:0] mepc_i,
  input logic            compressed_i,
  input logic            exc_illegal_o,
  input logic            exc_misaligned_o,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] status_o,
  input logic            halt_o,
  input logic            tlb_flush_o
);
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_illegal_o && exc_misaligned_o)); // R8

  AST_HOLD_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_illegal_o || exc_misaligned_o) |->
      ($stable(pc_o) && $stable(priv_o) && $stable(status_o))); // R8

  AST_MRET_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 4'b0010 && priv_i != 2'b11) |=> exc_illegal_o); // R1

  AST_SRET_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 4'b0001 && priv_i != 2'b00 && !compressed_i && sepc_i[1:0] != 2'b00)
      |=> (exc_misaligned_o && !exc_illegal_o)); // R2

  AST_MRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 4'b0010 && priv_i == 2'b11 && (compressed_i || mepc_i[1:0] == 2'b00))
      |=> (!status_o[7] && status_o[12:11] == 2'b00 && status_o[3] == $past(status_i[7])
           && pc_o == $past(mepc_i))); // R5

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |-> $past(req_i == 4'b1000)); // R7

  AST_HALT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 4'b0100 && !(priv_i == 2'b01 && status_i[21])) |=> (halt_o && !exc_illegal_o)); // R6

  AST_MULTI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_i) > 1) |=> (!exc_illegal_o && !exc_misaligned_o && !halt_o
                                 && !tlb_flush_o && $stable(priv_o))); // R9
endmodule

bind priv_ret_ctrl prc_checker #(.XLEN(XLEN)) u_prc_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_i            (req_i),
  .priv_i           (priv_i),
  .status_i         (status_i),
  .sepc_i           (sepc_i),
  .mepc_i           (mepc_i),
  .compressed_i     (compressed_i),
  .exc_illegal_o    (exc_illegal_o),
  .exc_misaligned_o (exc_misaligned_o),
  .pc_o             (pc_o),
  .priv_o           (priv_o),
  .status_o         (status_o),
  .halt_o           (halt_o),
  .tlb_flush_o      (tlb_flush_o)
);

// File: tb/priv_ret_ctrl_test.sv
module priv_ret_ctrl_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      req_i = '0;
  logic [1:0]      priv_i = '0;
  logic [XLEN-1:0] status_i = '0;
  logic [XLEN-1:0] sepc_i = '0;
  logic [XLEN-1:0] mepc_i = '0;
  logic            compressed_i = 1'b0;
  logic            exc_illegal_o, exc_misaligned_o, halt_o, tlb_flush_o;
  logic [XLEN-1:0] pc_o, status_o;
  logic [1:0]      priv_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [XLEN-1:0] m_pc;
  logic [XLEN-1:0] m_status;
  logic [1:0]      m_priv;

  always #2 clk = ~clk;

  priv_ret_ctrl #(.XLEN(XLEN)) uut (
    .clk, .rst_n, .req_i, .priv_i, .status_i, .sepc_i, .mepc_i, .compressed_i,
    .exc_illegal_o, .exc_misaligned_o, .pc_o, .priv_o, .status_o, .halt_o, .tlb_flush_o
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] r, input logic [1:0] p, input logic [31:0] st,
                       input logic [31:0] se, input logic [31:0] me, input logic c);
    @(negedge clk);
    req_i = r; priv_i = p; status_i = st; sepc_i = se; mepc_i = me; compressed_i = c;
    @(posedge clk);
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic check_all(input string tag, input logic ill, input logic mis,
                           input logic hlt, input logic fl);
    check(tag, "illegal", exc_illegal_o, ill);
    check(tag, "misaligned", exc_misaligned_o, mis);
    check(tag, "halt", halt_o, hlt);
    check(tag, "flush", tlb_flush_o, fl);
    check(tag, "pc", pc_o, m_pc);
    check(tag, "priv", priv_o, m_priv);
    check(tag, "status", status_o, m_status);
    @(posedge clk);
    @(negedge clk);
    check(tag, "pulses low next cycle",
          {exc_illegal_o, exc_misaligned_o, halt_o, tlb_flush_o}, 4'b0000);
  endtask

  function automatic logic [31:0] sret_st(input logic [31:0] s);
    logic [31:0] r = s;
    r[1] = s[5]; r[5] = 1'b0; r[8] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] mret_st(input logic [31:0] s);
    logic [31:0] r = s;
    r[3] = s[7]; r[7] = 1'b0; r[12:11] = 2'b00;
    return r;
  endfunction

  task automatic t_reset();
    m_pc = '0; m_status = '0; m_priv = 2'b11;
    check("R10", "reset priv", priv_o, 2'b11);
    check("R10", "reset status", status_o, 0);
    check("R10", "reset pc", pc_o, 0);
    check("R10", "reset pulses", {exc_illegal_o, exc_misaligned_o, halt_o, tlb_flush_o}, 0);
  endtask

  task automatic t_sret();
    logic [31:0] st = 32'h4000_0128; // SPP=1, SPIE=1, MIE=1, bit30 set
    issue(4'b0001, 2'b01, st, 32'h0000_1000, 32'h0, 1'b0);
    m_pc = 32'h1000; m_priv = 2'b01; m_status = sret_st(st);
    check_all("R4", 1'b0, 1'b0, 1'b0, 1'b0);
    st = 32'h0000_0002; // SPP=0, SPIE=0, SIE=1
    issue(4'b0001, 2'b11, st, 32'h0000_2000, 32'h0, 1'b0);
    m_pc = 32'h2000; m_priv = 2'b00; m_status = sret_st(st);
    check_all("R4", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sret_illegal();
    issue(4'b0001, 2'b00, 32'h0000_0120, 32'h0000_3000, 32'h0, 1'b0);
    check_all("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    // Misaligned target with TSR set: misaligned wins
    issue(4'b0001, 2'b01, 32'h0040_0120, 32'h0000_3002, 32'h0, 1'b0);
    check_all("R3", 1'b0, 1'b1, 1'b0, 1'b0);
    // Compressed supported: alignment passes, TSR traps
    issue(4'b0001, 2'b01, 32'h0040_0120, 32'h0000_3002, 32'h0, 1'b1);
    check_all("R3", 1'b1, 1'b0, 1'b0, 1'b0);
    // Priv check ranks above alignment
    issue(4'b0001, 2'b00, 32'h0, 32'h0000_3001, 32'h0, 1'b0);
    check_all("R1", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sret_compressed();
    logic [31:0] st = 32'h0000_0020;
    issue(4'b0001, 2'b01, st, 32'h0000_3002, 32'h0, 1'b1);
    m_pc = 32'h3002; m_priv = 2'b00; m_status = sret_st(st);
    check_all("R2", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mret();
    logic [31:0] st = 32'h0000_0880; // MPP=01, MPIE=1
    issue(4'b0010, 2'b11, st, 32'h0, 32'h0000_4000, 1'b0);
    m_pc = 32'h4000; m_priv = 2'b01; m_status = mret_st(st);
    check_all("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    st = 32'h8000_1008; // MPP=10 reserved, MIE=1, MPIE=0
    issue(4'b0010, 2'b11, st, 32'h0, 32'h0000_5000, 1'b0);
    m_pc = 32'h5000; m_priv = 2'b00; m_status = mret_st(st);
    check_all("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    st = 32'h0000_1880; // MPP=11
    issue(4'b0010, 2'b11, st, 32'h0, 32'h0000_6000, 1'b0);
    m_pc = 32'h6000; m_priv = 2'b11; m_status = mret_st(st);
    check_all("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    issue(4'b0010, 2'b01, 32'h0000_1880, 32'h0, 32'h0000_7000, 1'b0);
    check_all("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    issue(4'b0010, 2'b11, 32'h0000_1880, 32'h0, 32'h0000_7001, 1'b0);
    check_all("R2", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_wfi();
    issue(4'b0100, 2'b01, 32'h0020_0000, 32'h0, 32'h0, 1'b0);
    check_all("R6", 1'b1, 1'b0, 1'b0, 1'b0);
    issue(4'b0100, 2'b01, 32'h0010_0000, 32'h0, 32'h0, 1'b0);
    check_all("R6", 1'b0, 1'b0, 1'b1, 1'b0);
    issue(4'b0100, 2'b00, 32'h0020_0000, 32'h0, 32'h0, 1'b0);
    check_all("R6", 1'b0, 1'b0, 1'b1, 1'b0);
    issue(4'b0100, 2'b11, 32'h0020_0000, 32'h0, 32'h0, 1'b0);
    check_all("R6", 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_fence();
    issue(4'b1000, 2'b01, 32'h0010_0000, 32'h0, 32'h0, 1'b0);
    check_all("R7", 1'b1, 1'b0, 1'b0, 1'b0);
    issue(4'b1000, 2'b01, 32'h0020_0000, 32'h0, 32'h0, 1'b0);
    check_all("R7", 1'b0, 1'b0, 1'b0, 1'b1);
    issue(4'b1000, 2'b11, 32'h0010_0000, 32'h0, 32'h0, 1'b0);
    check_all("R7", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_malformed();
    issue(4'b0011, 2'b11, 32'h0000_08a0, 32'h0000_8000, 32'h0000_9000, 1'b0);
    check_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    issue(4'b1100, 2'b01, 32'h0, 32'h0, 32'h0, 1'b0);
    check_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    issue(4'b0000, 2'b11, 32'h0000_08a0, 32'h0000_8000, 32'h0000_9000, 1'b0);
    check_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sret();
    t_sret_illegal();
    t_sret_compressed();
    t_mret();
    t_wfi();
    t_fence();
    t_malformed();
    done = 1'b1;
    finish_run();
  end
endmodule